// File: doc/BRIEF.md
# Filtered Transactional Commit Queue

This block sits beside one core that runs transactions with lazy versioning and commit-time conflict detection. Each transactional store the core makes is checked for locality. A store goes to a thread-local location when it falls inside the running transaction's stack window or when its translated page carries a thread-local attribute. Such a store is dropped. Every other store has its address and data captured, in program order, into a small queue. Thread-local data never has to be published, so the bus beats it would have used during commit are saved.

When the core commits, the block raises a bus request and waits for the external bus arbiter to grant it. It holds the request, which acts as an exclusive bus lock, for the whole replay. It drives one queued store per cycle onto the bus so that remote cores can snoop every address. It then pulses a commit-done strobe and drops the lock in the same cycle. An abort empties the queue without touching the bus. Arbitration between cores, the cache arrays and remote snooping all live outside this block.

Top module: `commit_filter_queue`

## Requirements
- R1: After reset the bus request, bus valid and commit-done outputs are low, and the queue is empty: a commit issued straight after reset replays nothing.
- R2: A store that is not local is queued with its address and data. At commit the stored entries are replayed in the order they were accepted.
- R3: A store whose address lies between the stack lower bound and the stack upper bound, both bounds included, is local. It is not queued and is not stalled.
- R4: A store presented with the page-local flag high is local. It is not queued and is not stalled, whatever its address.
- R5: While the queue holds DEPTH entries, a non-local store raises the stall output and is not queued. A local store is still accepted with the stall output low.
- R6: A commit command raises the bus request in the next cycle. The request stays high until commit-done, and no replay beat appears before the grant has been seen.
- R7: Once the grant has been seen, the block drives exactly one queued store per cycle with bus valid high. The beats come back to back, and bus valid is never high outside a replay.
- R8: Commit-done is high for exactly one cycle, in the cycle after the last replay beat. The bus request is low in that same cycle.
- R9: A commit with an empty queue still holds the bus request for one granted cycle with no beat, then pulses commit-done.
- R10: An abort command empties the queue without raising the bus request. A store presented in the same cycle as the abort is discarded.
- R11: While a commit is in progress (request raised or commit-done high), every presented store is stalled and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Core presents a transactional store |
| stAddr | input | AW | Store word address |
| stData | input | DW | Store data |
| pageLocal | input | 1 | Thread-local attribute of the translated page |
| stackLo | input | AW | Lower stack bound of the running transaction (inclusive) |
| stackHi | input | AW | Upper stack bound of the running transaction (inclusive) |
| stStall | output | 1 | Store not accepted this cycle; core must hold it |
| cmdCommit | input | 1 | Commit the running transaction |
| cmdAbort | input | 1 | Abort the running transaction (wins over commit) |
| busReq | output | 1 | Bus request; held as the bus lock through replay |
| busGnt | input | 1 | Bus grant from the external arbiter |
| busValid | output | 1 | Replay beat valid |
| busAddr | output | AW | Replay beat address |
| busData | output | DW | Replay beat data |
| commitDone | output | 1 | One-cycle commit completion pulse |

## Verification
The bench probes the inclusive stack-window edges and the addresses one below and one above them. A comparator with the wrong strictness would either queue a stack word or drop a shared one, and the replayed beat list would then differ from the model. It fills the queue to exactly DEPTH entries and checks that the next shared store stalls while a local one does not. An off-by-one full flag would lose or overwrite an entry. It also runs empty commits, aborts that collide with a store, and grants delayed by several cycles. A design that replayed before the grant, kept the lock one cycle too long, or let an aborted store leak into the next commit would show an extra, early or missing beat, or a misplaced commit-done.

// File: rtl/cfq_pkg.sv
package cfq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } cfqState_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } cfqStrobe_t;
endpackage

// File: rtl/cfq_datapath.sv
module cfq_datapath
  import cfq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  cfqStrobe_t    strobe,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          pageLocal,
  input  logic [AW-1:0] stackLo,
  input  logic [AW-1:0] stackHi,
  output logic          isLocal,
  output logic          qFull,
  output logic          qEmpty,
  output logic          qAtLast,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = AW + DW;

  logic [EW-1:0] entries [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          inStack;

  // Locality classification: inclusive stack window or local page
  assign inStack = (stAddr >= stackLo) && (stAddr <= stackHi);
  assign isLocal = inStack || pageLocal;

  assign qFull   = (count == CW'(DEPTH));
  assign qEmpty  = (count == '0);
  assign qAtLast = (count <= CW'(1));
  assign {headAddr, headData} = entries[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) entries[wrPtr] <= {stAddr, stData};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cfq_control.sv
module cfq_control
  import cfq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stValid,
  input  logic       isLocal,
  input  logic       qFull,
  input  logic       qEmpty,
  input  logic       qAtLast,
  input  logic       cmdCommit,
  input  logic       cmdAbort,
  input  logic       busGnt,
  output cfqStrobe_t strobe,
  output logic       stStall,
  output logic       busReq,
  output logic       busValid,
  output logic       commitDone
);
  cfqState_e state, stateNext;
  logic      running;

  assign running = (state == ST_RUN);

  always_comb begin
    strobe.clear = running && cmdAbort;
    strobe.push  = running && stValid && !isLocal && !qFull && !cmdAbort;
    strobe.pop   = (state == ST_DRAIN) && !qEmpty;
  end

  assign stStall    = stValid && (!running || (qFull && !isLocal));
  assign busReq     = (state == ST_WAIT) || (state == ST_DRAIN);
  assign busValid   = strobe.pop;
  assign commitDone = (state == ST_DONE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:   if (!cmdAbort && cmdCommit) stateNext = ST_WAIT;
      ST_WAIT:  if (busGnt) stateNext = ST_DRAIN;
      ST_DRAIN: if (qAtLast) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_RUN;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/commit_filter_queue.sv
module commit_filter_queue
  import cfq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          pageLocal,
  input  logic [AW-1:0] stackLo,
  input  logic [AW-1:0] stackHi,
  output logic          stStall,
  input  logic          cmdCommit,
  input  logic          cmdAbort,
  output logic          busReq,
  input  logic          busGnt,
  output logic          busValid,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busData,
  output logic          commitDone
);
  cfqStrobe_t strobe;
  logic isLocal, qFull, qEmpty, qAtLast;

  cfq_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .stAddr(stAddr), .stData(stData), .pageLocal(pageLocal),
    .stackLo(stackLo), .stackHi(stackHi),
    .isLocal(isLocal), .qFull(qFull), .qEmpty(qEmpty), .qAtLast(qAtLast),
    .headAddr(busAddr), .headData(busData)
  );

  cfq_control u_ctl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .isLocal(isLocal),
    .qFull(qFull), .qEmpty(qEmpty), .qAtLast(qAtLast),
    .cmdCommit(cmdCommit), .cmdAbort(cmdAbort), .busGnt(busGnt),
    .strobe(strobe), .stStall(stStall), .busReq(busReq),
    .busValid(busValid), .commitDone(commitDone)
  );
endmodule

// File: rtl/cfq_checker.sv
module cfq_checker (
  input logic clk,
  input logic rstN,
  input logic stValid,
  input logic stStall,
  input logic cmdCommit,
  input logic cmdAbort,
  input logic busReq,
  input logic busGnt,
  input logic busValid,
  input logic commitDone
);
  // R8
  done_drops_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> !busReq);

  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |=> !commitDone);

  // R8
  lock_release_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> commitDone);

  // R7
  beat_inside_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busReq);

  // R6
  beat_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ($past(busGnt) || $past(busValid)));

  // R11
  stall_while_committing_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((busReq || commitDone) && stValid) |-> stStall);

  // R10
  abort_keeps_bus_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busReq && !commitDone && cmdAbort) |=> !busReq);

  // R6
  commit_raises_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busReq && !commitDone && cmdCommit && !cmdAbort) |=> busReq);
endmodule

bind commit_filter_queue cfq_checker u_chk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stStall(stStall),
  .cmdCommit(cmdCommit), .cmdAbort(cmdAbort), .busReq(busReq),
  .busGnt(busGnt), .busValid(busValid), .commitDone(commitDone)
);

// File: tb/commit_filter_queue_tb.sv
module commit_filter_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0, pageLocal = 1'b0, cmdCommit = 1'b0, cmdAbort = 1'b0, busGnt = 1'b0;
  logic [AW-1:0] stAddr = '0, stackLo = 16'h8000, stackHi = 16'h80FF;
  logic [DW-1:0] stData = '0;
  logic stStall, busReq, busValid, commitDone;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [AW-1:0] mAddr [DEPTH];
  logic [DW-1:0] mData [DEPTH];
  int mCnt = 0;

  commit_filter_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .pageLocal(pageLocal), .stackLo(stackLo), .stackHi(stackHi), .stStall(stStall),
    .cmdCommit(cmdCommit), .cmdAbort(cmdAbort), .busReq(busReq), .busGnt(busGnt),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .commitDone(commitDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit expLocal(input logic [AW-1:0] a, input logic pl);
    return pl || (a >= stackLo && a <= stackHi);
  endfunction

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // One store cycle: drive at negedge, check just after, commit to model after posedge
  task automatic doStore(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic pl,
                         input string req);
    bit loc, stall;
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d; pageLocal = pl;
    #1;
    loc = expLocal(a, pl);
    stall = !loc && (mCnt == DEPTH);
    chk(stStall == stall, req, "stStall on store", 32'(stStall), 32'(stall));
    @(posedge clk);
    if (!loc && !stall) begin
      mAddr[mCnt] = a; mData[mCnt] = d; mCnt++;
    end
    @(negedge clk);
    stValid = 1'b0; pageLocal = 1'b0;
  endtask

  task automatic doAbort(input bit withStore);
    @(negedge clk);
    cmdAbort = 1'b1;
    if (withStore) begin stValid = 1'b1; stAddr = 16'h1234; stData = 16'hDEAD; pageLocal = 1'b0; end
    #1;
    chk(busReq == 1'b0, "R10", "busReq during abort", 32'(busReq), 32'd0);
    @(posedge clk);
    mCnt = 0;
    @(negedge clk);
    cmdAbort = 1'b0; stValid = 1'b0;
    #1;
    chk(busReq == 1'b0, "R10", "busReq after abort", 32'(busReq), 32'd0);
  endtask

  task automatic doCommit(input int waitCycles, input string req);
    @(negedge clk);
    cmdCommit = 1'b1;
    #1;
    chk(busReq == 1'b0, "R6", "busReq before commit", 32'(busReq), 32'd0);
    @(posedge clk);
    @(negedge clk);
    cmdCommit = 1'b0;
    for (int w = 0; w < waitCycles; w++) begin
      stValid = (w == 0); stAddr = 16'h0042; pageLocal = 1'b0;
      #1;
      chk(busReq == 1'b1, "R6", "busReq while waiting", 32'(busReq), 32'd1);
      chk(busValid == 1'b0, "R6", "beat before grant", 32'(busValid), 32'd0);
      if (w == 0) chk(stStall == 1'b1, "R11", "store stalled in commit", 32'(stStall), 32'd1);
      @(posedge clk);
      @(negedge clk);
    end
    stValid = 1'b0;
    busGnt = 1'b1;
    #1;
    chk(busReq == 1'b1, "R6", "busReq at grant", 32'(busReq), 32'd1);
    chk(busValid == 1'b0, "R6", "beat in grant cycle", 32'(busValid), 32'd0);
    @(posedge clk);
    if (mCnt == 0) begin
      @(negedge clk); #1;
      chk(busReq == 1'b1, "R9", "empty commit lock cycle", 32'(busReq), 32'd1);
      chk(busValid == 1'b0, "R9", "empty commit beat", 32'(busValid), 32'd0);
      @(posedge clk);
    end
    for (int i = 0; i < mCnt; i++) begin
      @(negedge clk);
      stValid = (i == 0); stAddr = 16'h0043; pageLocal = 1'b0;
      #1;
      chk(busValid == 1'b1, req, "beat valid", 32'(busValid), 32'd1);
      chk(busAddr == mAddr[i], req, "beat addr", 32'(busAddr), 32'(mAddr[i]));
      chk(busData == mData[i], req, "beat data", 32'(busData), 32'(mData[i]));
      if (i == 0) chk(stStall == 1'b1, "R11", "store stalled in replay", 32'(stStall), 32'd1);
      @(posedge clk);
    end
    @(negedge clk);
    stValid = 1'b0;
    #1;
    chk(commitDone == 1'b1, "R8", "commitDone after last beat", 32'(commitDone), 32'd1);
    chk(busReq == 1'b0, "R8", "lock released with done", 32'(busReq), 32'd0);
    chk(busValid == 1'b0, "R7", "no extra beat", 32'(busValid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    busGnt = 1'b0;
    #1;
    chk(commitDone == 1'b0, "R8", "commitDone single pulse", 32'(commitDone), 32'd0);
    mCnt = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(busReq == 0 && busValid == 0 && commitDone == 0 && stStall == 0, "R1",
        "outputs after reset", {busReq, busValid, commitDone, stStall}, 32'd0);
    doCommit(1, "R1");

    // Stack-window edges and page-local flag
    doStore(16'h8000, 16'h0001, 1'b0, "R3");
    doStore(16'h80FF, 16'h0002, 1'b0, "R3");
    doStore(16'h7FFF, 16'h0003, 1'b0, "R3");
    doStore(16'h8100, 16'h0004, 1'b0, "R3");
    doStore(16'h2000, 16'h0005, 1'b1, "R4");
    doStore(16'h2000, 16'h0006, 1'b0, "R2");
    doCommit(2, "R2");

    doCommit(0, "R9");

    // Fill to DEPTH and beyond
    for (int i = 0; i < DEPTH + 2; i++) doStore(16'(16'h3000 + i), 16'(16'hA000 + i), 1'b0, "R5");
    doStore(16'h8010, 16'hBEEF, 1'b0, "R5");
    doStore(16'h5555, 16'hBEEF, 1'b1, "R5");
    doCommit(0, "R5");

    // Abort with and without a colliding store
    doStore(16'h4000, 16'h1111, 1'b0, "R10");
    doStore(16'h4001, 16'h2222, 1'b0, "R10");
    doAbort(1'b1);
    doCommit(1, "R10");
    doStore(16'h4002, 16'h3333, 1'b0, "R10");
    doAbort(1'b0);
    doStore(16'h4003, 16'h4444, 1'b0, "R2");
    doCommit(0, "R2");

    // Constrained random transactions
    for (int t = 0; t < 40; t++) begin
      int n;
      stackLo = 16'($urandom_range(16'h7000, 16'h8000));
      stackHi = stackLo + 16'($urandom_range(0, 255));
      n = $urandom_range(0, DEPTH + 3);
      for (int s = 0; s < n; s++) begin
        logic [AW-1:0] a;
        int kind = $urandom_range(0, 3);
        if (kind == 0)      a = stackLo + 16'($urandom_range(0, 32'(stackHi - stackLo)));
        else if (kind == 1) a = ($urandom_range(0, 1) == 1) ? stackLo - 16'd1 : stackHi + 16'd1;
        else                a = 16'($urandom_range(0, 16'h6FFF));
        doStore(a, 16'($urandom), ($urandom_range(0, 4) == 0), "R2");
      end
      if ($urandom_range(0, 4) == 0) doAbort($urandom_range(0, 1) == 1);
      doCommit($urandom_range(0, 3), "R7");
    end

    finishRun();
  end
endmodule